// File: doc/BRIEF.md
# AES Key Register Bank

This block stores the cipher key for an AES engine in four 64-bit registers that software reaches over a simple register bus with per-byte write strobes. A separate key-size input selects a 128-, 192- or 256-bit key. Bytes that lie beyond the selected size are protected from writes, read back as zero and are driven as zero on the key vector. The whole bank returns to zero on reset and whenever the engine is asked to re-initialize.

The bank watches a busy input from the datapath. A bus write that arrives while a message is being processed does not reach the key. Instead it raises a sticky context-error flag. When processing begins, the bank asks the key-expansion logic for a new schedule with a single-cycle strobe. The exception is a restore-decrypt-key mode bit. Software sets this bit after it has read out an already-expanded decryption key and written it back, and in that case no expansion is requested. A context switch therefore skips the expansion delay.

Top module: `aes_keybank`

## Requirements
- R1: After reset the key vector, read data, context-error flag and expansion strobe are all zero.
- R2: `word_addr` 0..3 selects the register at byte offset 0x00, 0x08, 0x10 or 0x18. Write strobe bit j writes `wdata[8j+7:8j]` into byte lane j of that register. The key vector is {reg0, reg1, reg2, reg3}, so register 0 holds the first 8 key bytes in the most significant 64 bits.
- R3: Key-size encoding is 00 = 16 bytes, 01 = 24 bytes, 10 or 11 = 32 bytes. Key byte n sits in register n/8, lane 7-(n%8). A write to a byte at or beyond the selected size is discarded, and that byte keeps its earlier stored value.
- R4: A read returns the whole selected register in `rdata` on the clock edge that samples `rd_en`. Bytes beyond the key size read as zero and are zero on the key vector.
- R5: A `reinit` pulse clears every key byte and the context-error flag.
- R6: A write while `busy` is high leaves the stored key unchanged and sets the context-error flag.
- R7: The context-error flag stays set until reset, `reinit` or an `err_clr` pulse. If a new error and `err_clr` arrive in the same cycle, the flag stays set.
- R8: When `busy` rises while `restore_key` is low, `expand_req` is high for exactly one cycle, namely the cycle after the edge that first samples `busy` high.
- R9: When `busy` rises while `restore_key` is high, `expand_req` stays low and the key vector keeps the written-back value.
- R10: A key read out and later written back after a re-initialize reproduces the same key vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reinit | input | 1 | Engine re-initialize request, clears the bank |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| word_addr | input | 2 | Register select (byte offset divided by 8) |
| wdata | input | 64 | Write data |
| wstrb | input | 8 | Byte write strobes |
| rdata | output | 64 | Read data, registered |
| key_size | input | 2 | Key length code |
| busy | input | 1 | Message processing in progress |
| restore_key | input | 1 | Restore-decrypt-key mode bit |
| err_clr | input | 1 | Clears the context-error flag |
| key_out | output | 256 | Masked key vector |
| expand_req | output | 1 | One-cycle key-expansion request |
| ctx_err | output | 1 | Sticky context-error flag |

## Verification
The hardest case to set up is showing that a discarded write kept the old byte. Stored bytes beyond the key size are hidden at the ports, so the stimulus first writes the register under a 256-bit size. It then shrinks the size and writes different data to the same register. Finally it widens the size again and reads the register back, expecting the first value. A similar sequence proves that a rejected write during processing kept the key: after `busy` drops, the bench reads the register back. It also drives a rejected write and an error clear in the same cycle to check which one wins.

// File: rtl/aes_kb_pkg.sv
// Package: shared sizes and key-length decoding for the AES key bank.
// Assumes registers of 64 bits split into 8-bit lanes.
package aes_kb_pkg;

    localparam int KB_REG_W    = 64;
    localparam int KB_NUM_REGS = 4;

    typedef enum logic [1:0] {
        KSZ_128  = 2'b00,
        KSZ_192  = 2'b01,
        KSZ_256  = 2'b10,
        KSZ_256X = 2'b11
    } key_size_e;

    // Number of key bytes enabled by a key-size code.
    function automatic int key_bytes(input logic [1:0] code);
        case (code)
            KSZ_128: key_bytes = 16;
            KSZ_192: key_bytes = 24;
            default: key_bytes = 32;
        endcase
    endfunction

endpackage

// File: rtl/kb_lane_map.sv
// Module: kb_lane_map
// Computes, for every stored byte, whether it lies inside the programmed key
// length. Byte lane j of register r holds key byte r*LANES + (LANES-1-j).
// Assumes a purely combinational use by the write and read paths.
module kb_lane_map
    import aes_kb_pkg::*;
#(
    parameter int REG_W    = KB_REG_W,
    parameter int NUM_REGS = KB_NUM_REGS
) (
    input  logic [1:0]                      key_size,
    output logic [NUM_REGS*(REG_W/8)-1:0]   lane_ok
);
    localparam int LANES = REG_W / 8;

    logic [31:0] limit;

    // Byte count for the current key-size code.
    always_comb limit = 32'(key_bytes(key_size));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            localparam int KEY_IDX = r * LANES + (LANES - 1 - j);
            // Lane is usable when its key byte index is below the length.
            assign lane_ok[r*LANES+j] = (32'(KEY_IDX) < limit);
        end
    end

endmodule

// File: rtl/kb_access_ctrl.sv
// Module: kb_access_ctrl
// Decodes bus writes into per-byte write enables. It blocks writes during
// processing, re-initialize and outside the key length, and keeps the sticky
// context-error flag. Assumes that busy is synchronous to clk.
module kb_access_ctrl
    import aes_kb_pkg::*;
#(
    parameter int REG_W    = KB_REG_W,
    parameter int NUM_REGS = KB_NUM_REGS
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    reinit,
    input  logic                                    wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]             word_addr,
    input  logic [REG_W/8-1:0]                      wstrb,
    input  logic                                    busy,
    input  logic                                    err_clr,
    input  logic [NUM_REGS*(REG_W/8)-1:0]           lane_ok,
    output logic [NUM_REGS*(REG_W/8)-1:0]           byte_we,
    output logic                                    ctx_err
);
    localparam int LANES = REG_W / 8;
    localparam int IDX_W = $clog2(NUM_REGS);

    logic wr_ok;
    logic err_hit;

    // A write may proceed only when idle and not re-initializing.
    always_comb wr_ok = wr_en & ~busy & ~reinit;

    // A write arriving during processing is an error (reinit takes priority).
    always_comb err_hit = wr_en & busy & ~reinit;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            // Per-byte enable: selected register, strobed lane, inside length.
            assign byte_we[r*LANES+j] = wr_ok & (word_addr == IDX_W'(r))
                                        & wstrb[j] & lane_ok[r*LANES+j];
        end
    end

    // Sticky error flag: set beats clear, reset and reinit clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) begin
            ctx_err <= 1'b0;
        end else if (err_hit) begin
            ctx_err <= 1'b1;
        end else if (err_clr) begin
            ctx_err <= 1'b0;
        end
    end

    // R6: a write during processing leaves the flag set next cycle.
    p_busy_write_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy && !reinit) |=> ctx_err);

    // R7: the flag holds without a clear source.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_err && !err_clr && !reinit) |=> ctx_err);

    // R6: no byte enable fires while busy.
    p_no_we_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (byte_we == '0));

endmodule

// File: rtl/kb_reg_array.sv
// Module: kb_reg_array
// Byte-granular key storage. Each byte loads from its lane of wdata when its
// enable is set. Everything clears on reset and on reinit. Register r lives
// at bits [r*REG_W +: REG_W] of the flat store.
module kb_reg_array
    import aes_kb_pkg::*;
#(
    parameter int REG_W    = KB_REG_W,
    parameter int NUM_REGS = KB_NUM_REGS
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                reinit,
    input  logic [NUM_REGS*(REG_W/8)-1:0]       byte_we,
    input  logic [REG_W-1:0]                    wdata,
    output logic [NUM_REGS*REG_W-1:0]           store
);
    localparam int LANES = REG_W / 8;
    localparam int NBYTE = NUM_REGS * LANES;

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        localparam int LANE = b % LANES;
        // One key byte: cleared by reset/reinit, loaded when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n || reinit) begin
                store[b*8 +: 8] <= 8'h00;
            end else if (byte_we[b]) begin
                store[b*8 +: 8] <= wdata[LANE*8 +: 8];
            end
        end
    end

    // R5: a reinit leaves the whole bank zero.
    p_reinit_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (store == '0));

    // R3: bytes without an enable keep their value.
    p_hold_without_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we == '0 && !reinit) |=> $stable(store));

endmodule

// File: rtl/kb_start_ctrl.sv
// Module: kb_start_ctrl
// Detects the start of processing (busy rising). It issues a one-cycle
// expansion request unless the restore-decrypt-key bit says the stored key is
// already expanded.
module kb_start_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic reinit,
    input  logic busy,
    input  logic restore_key,
    output logic expand_req
);
    logic busy_q;

    // Remember busy from the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Request expansion on the first busy cycle unless restoring.
    always_ff @(posedge clk) begin
        if (!rst_n) expand_req <= 1'b0;
        else        expand_req <= busy & ~busy_q & ~restore_key & ~reinit;
    end

    // R8: the request is a single-cycle pulse.
    p_expand_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expand_req |=> !expand_req);

    // R9: a restored key never triggers expansion.
    p_restore_skips_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !busy_q && restore_key) |=> !expand_req);

endmodule

// File: rtl/aes_keybank.sv
// Module: aes_keybank (top)
// Key register bank for an AES engine: byte-strobed writes, length masking,
// write protection during processing, sticky context error and the
// expansion-request strobe. Read data is registered. Assumes that all inputs
// are synchronous to clk.
module aes_keybank
    import aes_kb_pkg::*;
#(
    parameter int REG_W    = KB_REG_W,
    parameter int NUM_REGS = KB_NUM_REGS,
    localparam int LANES   = REG_W / 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reinit,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [IDX_W-1:0]            word_addr,
    input  logic [REG_W-1:0]            wdata,
    input  logic [LANES-1:0]            wstrb,
    output logic [REG_W-1:0]            rdata,
    input  logic [1:0]                  key_size,
    input  logic                        busy,
    input  logic                        restore_key,
    input  logic                        err_clr,
    output logic [NUM_REGS*REG_W-1:0]   key_out,
    output logic                        expand_req,
    output logic                        ctx_err
);
    logic [NUM_REGS*LANES-1:0] lane_ok;
    logic [NUM_REGS*LANES-1:0] byte_we;
    logic [NUM_REGS*REG_W-1:0] store;
    logic [NUM_REGS*REG_W-1:0] masked;

    kb_lane_map #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_lane_map (
        .key_size (key_size),
        .lane_ok  (lane_ok)
    );

    kb_access_ctrl #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .reinit    (reinit),
        .wr_en     (wr_en),
        .word_addr (word_addr),
        .wstrb     (wstrb),
        .busy      (busy),
        .err_clr   (err_clr),
        .lane_ok   (lane_ok),
        .byte_we   (byte_we),
        .ctx_err   (ctx_err)
    );

    kb_reg_array #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .reinit  (reinit),
        .byte_we (byte_we),
        .wdata   (wdata),
        .store   (store)
    );

    kb_start_ctrl u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .reinit      (reinit),
        .busy        (busy),
        .restore_key (restore_key),
        .expand_req  (expand_req)
    );

    for (genvar b = 0; b < NUM_REGS*LANES; b++) begin : g_mask
        // Hide bytes outside the key length.
        assign masked[b*8 +: 8] = lane_ok[b] ? store[b*8 +: 8] : 8'h00;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_pack
        // Register 0 forms the most significant word of the key vector.
        assign key_out[(NUM_REGS-1-r)*REG_W +: REG_W] = masked[r*REG_W +: REG_W];
    end

    // Registered read port returning one whole masked register.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= masked[word_addr*REG_W +: REG_W];
    end

    // R6: a write during processing leaves the stored key untouched.
    p_busy_keeps_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy && !reinit) |=> $stable(store));

    // R4: reading a register wholly outside the key length returns zero.
    p_mask_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lane_ok[word_addr*LANES +: LANES] == '0) |=> (rdata == '0));

endmodule

// File: tb/aes_keybank_tb.sv
// Directed bench for aes_keybank. Each task checks its own scenario.
module aes_keybank_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reinit = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   word_addr = '0;
    logic [63:0]  wdata = '0;
    logic [7:0]   wstrb = '0;
    logic [63:0]  rdata;
    logic [1:0]   key_size = 2'b10;
    logic         busy = 1'b0;
    logic         restore_key = 1'b0;
    logic         err_clr = 1'b0;
    logic [255:0] key_out;
    logic         expand_req;
    logic         ctx_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [63:0] K0 = 64'h0011223344556677;
    localparam logic [63:0] K1 = 64'h8899AABBCCDDEEFF;
    localparam logic [63:0] K2 = 64'h0123456789ABCDEF;
    localparam logic [63:0] K3 = 64'hFEDCBA9876543210;

    always #5 clk = ~clk;

    aes_keybank u_dut (
        .clk(clk), .rst_n(rst_n), .reinit(reinit), .wr_en(wr_en), .rd_en(rd_en),
        .word_addr(word_addr), .wdata(wdata), .wstrb(wstrb), .rdata(rdata),
        .key_size(key_size), .busy(busy), .restore_key(restore_key),
        .err_clr(err_clr), .key_out(key_out), .expand_req(expand_req),
        .ctx_err(ctx_err)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [63:0] d, input logic [7:0] s);
        @(negedge clk);
        wr_en = 1'b1; word_addr = a; wdata = d; wstrb = s;
        @(negedge clk);
        wr_en = 1'b0; wstrb = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [63:0] d);
        @(negedge clk);
        rd_en = 1'b1; word_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse_reinit();
        @(negedge clk); reinit = 1'b1;
        @(negedge clk); reinit = 1'b0;
    endtask

    task automatic load_all();
        key_size = 2'b10;
        bus_write(2'd0, K0, 8'hFF);
        bus_write(2'd1, K1, 8'hFF);
        bus_write(2'd2, K2, 8'hFF);
        bus_write(2'd3, K3, 8'hFF);
    endtask

    // Counts expand_req cycles after busy rises, then drops busy.
    task automatic start_and_count(output int pulses);
        pulses = 0;
        @(negedge clk); busy = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (expand_req) pulses++;
        end
        busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 key_out", key_out, '0);
        check("R1 rdata", 256'(rdata), '0);
        check("R1 ctx_err", 256'(ctx_err), '0);
        check("R1 expand_req", 256'(expand_req), '0);
    endtask

    task automatic t_map();
        logic [63:0] d;
        load_all();
        @(negedge clk);
        check("R2 key packing", key_out, {K0, K1, K2, K3});
        bus_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F);
        bus_read(2'd1, d);
        check("R2 byte strobes / R4 read", 256'(d), 256'({K1[63:32], 32'hFFFF_FFFF}));
        bus_write(2'd1, K1, 8'hFF);
    endtask

    task automatic t_size();
        logic [63:0] d;
        key_size = 2'b00;
        @(negedge clk);
        check("R4 key_out 128 mask", key_out, {K0, K1, 128'h0});
        bus_read(2'd2, d);
        check("R4 read beyond size", 256'(d), '0);
        bus_write(2'd3, 64'h5555_5555_5555_5555, 8'hFF);
        key_size = 2'b10;
        bus_read(2'd3, d);
        check("R3 discarded write keeps old", 256'(d), 256'(K3));
        key_size = 2'b01;
        bus_read(2'd2, d);
        check("R3 192 reg2 visible", 256'(d), 256'(K2));
        bus_read(2'd3, d);
        check("R3 192 reg3 hidden", 256'(d), '0);
        key_size = 2'b11;
        @(negedge clk);
        check("R3 code 11 is 256", key_out, {K0, K1, K2, K3});
        key_size = 2'b10;
    endtask

    task automatic t_busy();
        logic [63:0] d;
        restore_key = 1'b1;
        @(negedge clk); busy = 1'b1;
        bus_write(2'd0, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF);
        check("R6 ctx_err set", 256'(ctx_err), 256'(1));
        busy = 1'b0;
        bus_read(2'd0, d);
        check("R6 key unchanged", 256'(d), 256'(K0));
        repeat (3) @(negedge clk);
        check("R7 sticky", 256'(ctx_err), 256'(1));
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        check("R7 err_clr", 256'(ctx_err), '0);
        busy = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; word_addr = 2'd0; wdata = '0; wstrb = 8'hFF; err_clr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wstrb = '0; err_clr = 1'b0; busy = 1'b0;
        check("R7 set wins over clear", 256'(ctx_err), 256'(1));
        restore_key = 1'b0;
    endtask

    task automatic t_reinit();
        pulse_reinit();
        check("R5 key cleared", key_out, '0);
        check("R5 ctx_err cleared", 256'(ctx_err), '0);
    endtask

    task automatic t_expand();
        int p;
        restore_key = 1'b0;
        start_and_count(p);
        check("R8 single expand pulse", 256'(p), 256'(1));
    endtask

    task automatic t_restore();
        logic [63:0] s [4];
        int p;
        load_all();
        for (int i = 0; i < 4; i++) bus_read(2'(i), s[i]);
        pulse_reinit();
        for (int i = 0; i < 4; i++) bus_write(2'(i), s[i], 8'hFF);
        @(negedge clk);
        check("R10 round trip", key_out, {K0, K1, K2, K3});
        restore_key = 1'b1;
        start_and_count(p);
        check("R9 no expand on restore", 256'(p), '0);
        check("R9 key kept", key_out, {K0, K1, K2, K3});
        restore_key = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_size();
        t_busy();
        t_reinit();
        t_expand();
        t_restore();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule